// File: doc/BRIEF.md
# Board Interrupt Expander

This block gathers up to sixteen peripheral interrupt sources on a board-level logic device and presents them to the host processor as one active-high, level-sensitive request. Each source is synchronized with two flops, and its rising edge sets a sticky pending bit. A per-line enable mask decides which pending bits may raise the request.

Software reaches the block through a small synchronous 16-bit register port. The mask cannot be written directly. Ones written to one address turn lines on, and ones written to another address turn lines off. Pending bits are cleared by writing ones to the pending register. A service routine reads the pending bits and the mask, ANDs them, and handles every line that is set, starting from line 0. By board convention, line 8 carries the Ethernet controller, and lines 10 and 11 carry the two external UART channels.

Top module: `irq_expander`

## Requirements
- R1: After reset, the enable mask reads 0x0000, the pending register reads 0x0000, and `irq_out` is low.
- R2: A low-to-high transition on `src_in[n]` sets pending bit n. The bit is readable three clock edges after the input changes. A level that stays high does not set the bit again once it has been cleared, and a falling transition sets nothing.
- R3: A read at offset 0x18 returns the synchronized levels of `src_in`, with no latching and no masking.
- R4: A write at offset 0x1A sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A write at offset 0x1C clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R6: A read at offset 0x1A or at offset 0x1C returns the current mask, where 1 means the line is enabled.
- R7: A write at offset 0x16 clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged. Writing 0xFFFF clears all of them.
- R8: If a new rising edge on line n and a clear of pending bit n land on the same clock edge, the bit ends up set.
- R9: `irq_out` is high exactly while at least one bit is set in both the pending register and the mask.
- R10: The value for a read appears on `rdata` one clock after `rd_en`. An unmapped offset reads 0, and `rdata` is 0 in any cycle that follows a cycle without `rd_en`.
- R11: Writes at offset 0x18 or at an unmapped offset change neither the mask nor the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register offset within the block window |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 16 | Write data, bit n belongs to line n |
| rdata | output | 16 | Registered read data |
| src_in | input | 16 | Raw peripheral interrupt levels |
| irq_out | output | 1 | Summary interrupt to the host, active high |

## Verification
The hardest case to reach from the ports is the collision in which a clear write and a freshly synchronized edge hit the same pending bit on the same clock edge. The source is raised on a falling clock edge, two more falling edges are counted, and the clear write is then placed so that it lands on the third rising edge. That is the edge on which the synchronized transition reaches the pending register. Every line is also swept on its own through set, partial clear, mask off and on, full clear, a held level, and release. The mask is then exercised with arithmetic patterns on both the set and clear addresses.

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 8,
  parameter bit [ADDR_W-1:0] OFS_PEND  = 'h16,
  parameter bit [ADDR_W-1:0] OFS_RAW   = 'h18,
  parameter bit [ADDR_W-1:0] OFS_ENSET = 'h1A,
  parameter bit [ADDR_W-1:0] OFS_ENCLR = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  input  logic [LINES-1:0]  src_in,
  output logic              irq_out
);

  logic [LINES-1:0] sync1, sync2, prev, pend, en, rise, rd_val;
  logic hit_pend, hit_set, hit_clr;

  assign rise     = sync2 & ~prev;
  assign hit_pend = wr_en && (addr == OFS_PEND);
  assign hit_set  = wr_en && (addr == OFS_ENSET);
  assign hit_clr  = wr_en && (addr == OFS_ENCLR);
  assign irq_out  = |(pend & en);

  always_comb begin
    case (addr)
      OFS_PEND:  rd_val = pend;
      OFS_RAW:   rd_val = sync2;
      OFS_ENSET: rd_val = en;
      OFS_ENCLR: rd_val = en;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      pend  <= '0;
      en    <= '0;
      rdata <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      prev  <= sync2;
      pend  <= (pend & ~(hit_pend ? wdata : '0)) | rise;
      if (hit_set) en <= en | wdata;
      else if (hit_clr) en <= en & ~wdata;
      rdata <= rd_en ? rd_val : '0;
    end
  end

  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pend && !(|rise)) |=> ((pend & $past(wdata)) == '0));

  p_mask_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> ((en & $past(wdata)) == $past(wdata)));

  p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> ((en & $past(wdata)) == '0));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_set || hit_clr) |=> $stable(en));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !hit_pend && !hit_clr) |=> irq_out);

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

endmodule

// File: tb/tb_irq_expander.sv
module tb_irq_expander;
  localparam logic [7:0] A_PEND = 8'h16, A_RAW = 8'h18, A_SET = 8'h1A, A_CLR = 8'h1C;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq_out;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0, rdata, src_in = '0;
  int checks = 0, errs = 0;
  logic [15:0] exp_mask, v;

  always #2.5 clk = ~clk;

  irq_expander dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                    .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq_out(irq_out));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'd0, irq_out}, 16'h0);
    rd(A_SET, v);  chk("R1 mask", v, 16'h0);
    rd(A_PEND, v); chk("R1 pending", v, 16'h0);
    @(negedge clk);
    chk("R10 rdata idle", rdata, 16'h0);

    // per-line sweep: R2 R3 R7 R9
    for (int n = 0; n < 16; n++) begin
      logic [15:0] b;
      b = 16'h1 << n;
      wr(A_CLR, 16'hFFFF);
      wr(A_PEND, 16'hFFFF);
      wr(A_SET, b);
      src_in = b;
      repeat (3) @(negedge clk);
      rd(A_PEND, v); chk("R2 edge latched", v, b);
      rd(A_RAW, v);  chk("R3 raw level", v, b);
      chk("R9 irq on", {15'd0, irq_out}, 16'h1);
      wr(A_PEND, ~b);
      rd(A_PEND, v); chk("R7 other bits kept", v, b);
      wr(A_CLR, b);
      chk("R9 masked", {15'd0, irq_out}, 16'h0);
      rd(A_PEND, v); chk("R9 pending kept while masked", v, b);
      wr(A_SET, b);
      chk("R9 unmasked", {15'd0, irq_out}, 16'h1);
      wr(A_PEND, b);
      chk("R7 irq after clear", {15'd0, irq_out}, 16'h0);
      repeat (3) @(negedge clk);
      rd(A_PEND, v); chk("R2 held level no relatch", v, 16'h0);
      src_in = '0;
      repeat (3) @(negedge clk);
      rd(A_PEND, v); chk("R2 falling edge", v, 16'h0);
      rd(A_RAW, v);  chk("R3 raw low", v, 16'h0);
    end

    // mask arithmetic sweep: R4 R5 R6
    wr(A_CLR, 16'hFFFF);
    exp_mask = '0;
    for (int k = 0; k < 16; k++) begin
      logic [15:0] p, q;
      p = (16'h1 << k) ^ (16'(k) * 16'h1357);
      q = (16'(k) * 16'h0F0F) ^ (16'hA5A5 >> k);
      wr(A_SET, p); exp_mask = exp_mask | p;
      rd(A_SET, v); chk("R4 R6 mask set", v, exp_mask);
      wr(A_CLR, q); exp_mask = exp_mask & ~q;
      rd(A_CLR, v); chk("R5 R6 mask clear", v, exp_mask);
    end

    // R11 ignored writes; R10 unmapped read
    src_in = 16'hF0F0;
    repeat (3) @(negedge clk);
    src_in = '0;
    wr(A_RAW, 16'hFFFF);
    wr(8'h20, 16'hFFFF);
    rd(A_SET, v);  chk("R11 mask untouched", v, exp_mask);
    rd(A_PEND, v); chk("R11 pending untouched", v, 16'hF0F0);
    chk("R9 multi-line irq", {15'd0, irq_out}, {15'd0, |(16'hF0F0 & exp_mask)});
    rd(8'h20, v);  chk("R10 unmapped read", v, 16'h0);
    wr(A_PEND, 16'hFFFF);
    rd(A_PEND, v); chk("R7 full clear", v, 16'h0);

    // R8 set wins over clear on the same edge
    wr(A_SET, 16'h0020);
    src_in = 16'h0020;
    repeat (2) @(negedge clk);
    wr(A_PEND, 16'h0020);
    rd(A_PEND, v); chk("R8 set wins", v, 16'h0020);
    chk("R8 irq kept", {15'd0, irq_out}, 16'h1);
    wr(A_PEND, 16'h0020);
    rd(A_PEND, v); chk("R8 later clear", v, 16'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule